// File: doc/BRIEF.md
# Sub-Word Register Access Bridge with Paired-Field Shadowing

This block connects a host that issues byte, halfword and word register accesses to a register file that only accepts aligned 32-bit accesses. A byte or halfword read fetches the whole word and returns the addressed lane. A byte or halfword write becomes a 32-bit read-modify-write, so the other lanes of the word keep their values.

Two register words hold pairs of 16-bit fields that must not be written one half at a time. One word holds block size and block count. The other holds transfer mode and command. Halfword writes to block size, block count or transfer mode are collected in local shadow words and are not forwarded. A halfword write to the command field commits both words in a fixed order: the block word first, then the command word. While a shadow holds data that has not been committed, halfword reads of its fields return the shadow contents.

The bridge handles one host access at a time. Each access finishes with a one-cycle acknowledge after its last downstream transfer.

Top module: `subword_bridge`

## Requirements
- R1: Every downstream transfer is a 32-bit access at the host address with its two low bits forced to zero.
- R2: The access size is encoded on `host_size` as 0 = byte, 1 = halfword, 2 = word. A sub-word read returns the lane at bit shift (address × 8) AND 0x18, zero-extended to 32 bits.
- R3: A byte or halfword write to any address other than 0x04, 0x06, 0x0C or 0x0E is carried out as a downstream read followed by a write to the same word. Only the addressed lane changes (mask 0xFF or 0xFFFF).
- R4: A halfword write to transfer mode (0x0C) causes no downstream write. It is merged into the command shadow word and marks that shadow valid. The old value for the merge is the shadow word if it is valid, otherwise a downstream read of word 0x0C.
- R5: A halfword write to block size (0x04) or block count (0x06) causes no downstream write. It is merged into the block shadow word and marks that shadow valid. The old value is the shadow word if it is valid, otherwise a downstream read of word 0x04.
- R6: A halfword write to command (0x0E) first writes a valid block shadow to word 0x04 and clears its valid flag. It then writes the merged command word to word 0x0C and clears the command valid flag. This is one write when the block shadow is not valid and two writes in that order when it is.
- R7: The command write merges the new halfword into the command shadow contents. Those contents are kept after a commit and are never re-read from the register.
- R8: A halfword read of 0x0C returns the command shadow lane while that shadow is valid. A halfword read of 0x04 or 0x06 returns the block shadow lane while that shadow is valid. Otherwise these reads go downstream.
- R9: Word reads and word writes pass straight through as one downstream access and never use the shadows.
- R10: `host_ack` is a one-cycle pulse. It rises one cycle after the last downstream acknowledge, or one cycle after acceptance when no downstream access is needed. `host_rdata` is valid while `host_ack` is high. A downstream request holds its address and data until it is acknowledged.
- R11: Reset clears `host_ack`, `dn_req` and both shadow valid flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until `host_ack` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word |
| host_addr | input | AW | Host byte address |
| host_wdata | input | DW | Write data, right-aligned for sub-word sizes |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Read data, lane right-aligned |
| dn_req | output | 1 | Downstream request, held until `dn_ack` |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | AW | Word-aligned downstream address |
| dn_wdata | output | DW | Downstream write word |
| dn_ack | input | 1 | Downstream completion, one cycle |
| dn_rdata | input | DW | Downstream read word, valid with `dn_ack` |

## Verification
An access served from a shadow acknowledges on the first cycle after acceptance. A word read against a downstream model with one wait cycle acknowledges three cycles after the request is driven. A read-modify-write takes one full downstream round trip for each of its two transfers. The bench waits for `host_ack` at falling edges, reads `host_rdata` in that same half cycle, and checks the measured latency against these counts. It inspects the downstream write log only after the acknowledge, when every transfer of the access has completed. To expose stale shadow use, the bench writes the register model behind the bridge's back, so a result taken from the shadow differs from one taken from the register.

// File: rtl/subbr_pkg.sv
package subbr_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;
  typedef enum logic [1:0] {K_PLAIN, K_MODE, K_BLK, K_CMD} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_RD, S_FLUSH, S_WR, S_ACK} state_e;
  localparam int NSH    = 2;
  localparam int SH_CMD = 0;
  localparam int SH_BLK = 1;
endpackage

// File: rtl/subbr_lanes.sv
module subbr_lanes #(
  parameter int DW   = 32,
  parameter int ALSB = $clog2(DW / 8)
) (
  input  logic [DW-1:0]   src,
  input  logic [DW-1:0]   wdata,
  input  logic [ALSB-1:0] lane,
  input  logic [1:0]      size,
  output logic [DW-1:0]   ext,
  output logic [DW-1:0]   mrg
);
  import subbr_pkg::*;
  localparam int SW = ALSB + 3;

  logic [SW-1:0] shift;
  logic [DW-1:0] lowmask;
  logic [DW-1:0] mask;

  always_comb begin
    shift = {lane, 3'b000};
    case (size)
      SZ_BYTE: lowmask = DW'(32'h0000_00FF);
      SZ_HALF: lowmask = DW'(32'h0000_FFFF);
      default: lowmask = '1;
    endcase
    mask = (size == SZ_WORD) ? '1 : (lowmask << shift);
    ext  = (size == SZ_WORD) ? src : ((src >> shift) & lowmask);
    mrg  = (size == SZ_WORD) ? wdata
                             : ((src & ~mask) | ((wdata << shift) & mask));
  end
endmodule

// File: rtl/subbr_shadow.sv
module subbr_shadow #(
  parameter int DW  = 32,
  parameter int NSH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSH-1:0]          ld,
  input  logic [NSH-1:0]          clr,
  input  logic [DW-1:0]           din,
  output logic [NSH-1:0][DW-1:0]  word,
  output logic [NSH-1:0]          vld
);
  for (genvar g = 0; g < NSH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        word[g] <= '0;
        vld[g]  <= 1'b0;
      end else if (ld[g]) begin
        word[g] <= din;
        vld[g]  <= 1'b1;
      end else if (clr[g]) begin
        vld[g]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/subbr_ctrl.sv
module subbr_ctrl #(
  parameter int              AW      = 8,
  parameter int              DW      = 32,
  parameter int              ALSB    = $clog2(DW / 8),
  parameter int              NSH     = 2,
  parameter logic [AW-1:0]   BS_OFF  = AW'(8'h04),
  parameter logic [AW-1:0]   BC_OFF  = AW'(8'h06),
  parameter logic [AW-1:0]   TM_OFF  = AW'(8'h0C),
  parameter logic [AW-1:0]   CMD_OFF = AW'(8'h0E)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_req,
  input  logic                   host_we,
  input  logic [1:0]             host_size,
  input  logic [AW-1:0]          host_addr,
  input  logic [DW-1:0]          host_wdata,
  output logic                   host_ack,
  output logic [DW-1:0]          host_rdata,
  output logic                   dn_req,
  output logic                   dn_we,
  output logic [AW-1:0]          dn_addr,
  output logic [DW-1:0]          dn_wdata,
  input  logic                   dn_ack,
  input  logic [DW-1:0]          dn_rdata,
  input  logic [NSH-1:0][DW-1:0] sh_word,
  input  logic [NSH-1:0]         sh_vld,
  output logic [NSH-1:0]         sh_ld,
  output logic [NSH-1:0]         sh_clr,
  output logic [DW-1:0]          sh_din,
  output logic [DW-1:0]          ln_src,
  output logic [DW-1:0]          ln_wdata,
  output logic [ALSB-1:0]        ln_lane,
  output logic [1:0]             ln_size,
  input  logic [DW-1:0]          ln_ext,
  input  logic [DW-1:0]          ln_mrg
);
  import subbr_pkg::*;

  localparam logic [AW-1:0] BS_WORD = {BS_OFF[AW-1:ALSB], ALSB'(0)};

  state_e        state, nx;
  logic          op_we;
  logic [1:0]    op_size;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;

  logic          cur_we;
  logic [1:0]    cur_size;
  logic [AW-1:0] cur_addr;
  kind_e         cur_kind;

  logic          iss, iss_we, drop, rd_ld;
  logic [AW-1:0] iss_addr;
  logic [DW-1:0] iss_data;

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
    return {a[AW-1:ALSB], ALSB'(0)};
  endfunction

  always_comb begin
    if (state == S_IDLE) begin
      cur_we   = host_we;
      cur_size = host_size;
      cur_addr = host_addr;
      ln_wdata = host_wdata;
    end else begin
      cur_we   = op_we;
      cur_size = op_size;
      cur_addr = op_addr;
      ln_wdata = op_wdata;
    end
    if (cur_size != SZ_HALF)                                cur_kind = K_PLAIN;
    else if (cur_addr == TM_OFF)                            cur_kind = K_MODE;
    else if (cur_addr == BS_OFF || cur_addr == BC_OFF)      cur_kind = K_BLK;
    else if (cur_addr == CMD_OFF)                           cur_kind = K_CMD;
    else                                                    cur_kind = K_PLAIN;

    if (state == S_RD)            ln_src = dn_rdata;
    else if (cur_kind == K_BLK)   ln_src = sh_word[SH_BLK];
    else                          ln_src = sh_word[SH_CMD];
    ln_lane = cur_addr[ALSB-1:0];
    ln_size = cur_size;
    sh_din  = ln_mrg;
  end

  always_comb begin
    nx       = state;
    iss      = 1'b0;
    iss_we   = 1'b0;
    iss_addr = align(cur_addr);
    iss_data = ln_mrg;
    drop     = 1'b0;
    rd_ld    = 1'b0;
    sh_ld    = '0;
    sh_clr   = '0;
    case (state)
      S_IDLE: if (host_req) begin
        if (!cur_we) begin
          if ((cur_kind == K_MODE && sh_vld[SH_CMD]) ||
              (cur_kind == K_BLK  && sh_vld[SH_BLK])) begin
            rd_ld = 1'b1;
            nx    = S_ACK;
          end else begin
            iss = 1'b1;
            nx  = S_RD;
          end
        end else if (cur_size == SZ_WORD) begin
          iss    = 1'b1;
          iss_we = 1'b1;
          nx     = S_WR;
        end else if (cur_kind == K_MODE && sh_vld[SH_CMD]) begin
          sh_ld[SH_CMD] = 1'b1;
          nx            = S_ACK;
        end else if (cur_kind == K_BLK && sh_vld[SH_BLK]) begin
          sh_ld[SH_BLK] = 1'b1;
          nx            = S_ACK;
        end else if (cur_kind == K_CMD) begin
          iss    = 1'b1;
          iss_we = 1'b1;
          if (sh_vld[SH_BLK]) begin
            iss_addr      = BS_WORD;
            iss_data      = sh_word[SH_BLK];
            sh_clr[SH_BLK] = 1'b1;
            nx            = S_FLUSH;
          end else begin
            sh_clr[SH_CMD] = 1'b1;
            nx             = S_WR;
          end
        end else begin
          iss = 1'b1;
          nx  = S_RD;
        end
      end
      S_RD: if (dn_ack) begin
        drop = 1'b1;
        if (!cur_we) begin
          rd_ld = 1'b1;
          nx    = S_ACK;
        end else if (cur_kind == K_MODE) begin
          sh_ld[SH_CMD] = 1'b1;
          nx            = S_ACK;
        end else if (cur_kind == K_BLK) begin
          sh_ld[SH_BLK] = 1'b1;
          nx            = S_ACK;
        end else begin
          iss    = 1'b1;
          iss_we = 1'b1;
          nx     = S_WR;
        end
      end
      S_FLUSH: if (dn_ack) begin
        iss            = 1'b1;
        iss_we         = 1'b1;
        sh_clr[SH_CMD] = 1'b1;
        nx             = S_WR;
      end
      S_WR: if (dn_ack) begin
        drop = 1'b1;
        nx   = S_ACK;
      end
      S_ACK:   nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      dn_req     <= 1'b0;
      dn_we      <= 1'b0;
      dn_addr    <= '0;
      dn_wdata   <= '0;
      op_we      <= 1'b0;
      op_size    <= '0;
      op_addr    <= '0;
      op_wdata   <= '0;
    end else begin
      state    <= nx;
      host_ack <= (nx == S_ACK);
      if (state == S_IDLE && host_req) begin
        op_we    <= host_we;
        op_size  <= host_size;
        op_addr  <= host_addr;
        op_wdata <= host_wdata;
      end
      if (iss) begin
        dn_req   <= 1'b1;
        dn_we    <= iss_we;
        dn_addr  <= iss_addr;
        dn_wdata <= iss_data;
      end else if (drop) begin
        dn_req   <= 1'b0;
      end
      if (rd_ld) host_rdata <= ln_ext;
    end
  end
endmodule

// File: rtl/subword_bridge.sv
module subword_bridge #(
  parameter int            AW      = 8,
  parameter int            DW      = 32,
  parameter logic [AW-1:0] BS_OFF  = AW'(8'h04),
  parameter logic [AW-1:0] BC_OFF  = AW'(8'h06),
  parameter logic [AW-1:0] TM_OFF  = AW'(8'h0C),
  parameter logic [AW-1:0] CMD_OFF = AW'(8'h0E)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [1:0]    host_size,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic          dn_req,
  output logic          dn_we,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_ack,
  input  logic [DW-1:0] dn_rdata
);
  import subbr_pkg::*;
  localparam int ALSB = $clog2(DW / 8);

  logic [NSH-1:0][DW-1:0] sh_word;
  logic [NSH-1:0]         sh_vld, sh_ld, sh_clr;
  logic [DW-1:0]          sh_din, ln_src, ln_wdata, ln_ext, ln_mrg;
  logic [ALSB-1:0]        ln_lane;
  logic [1:0]             ln_size;

  subbr_ctrl #(
    .AW(AW), .DW(DW), .ALSB(ALSB), .NSH(NSH),
    .BS_OFF(BS_OFF), .BC_OFF(BC_OFF), .TM_OFF(TM_OFF), .CMD_OFF(CMD_OFF)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_size(host_size),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata),
    .sh_word(sh_word), .sh_vld(sh_vld), .sh_ld(sh_ld), .sh_clr(sh_clr),
    .sh_din(sh_din),
    .ln_src(ln_src), .ln_wdata(ln_wdata), .ln_lane(ln_lane), .ln_size(ln_size),
    .ln_ext(ln_ext), .ln_mrg(ln_mrg)
  );

  subbr_shadow #(.DW(DW), .NSH(NSH)) u_shadow (
    .clk(clk), .rst(rst), .ld(sh_ld), .clr(sh_clr), .din(sh_din),
    .word(sh_word), .vld(sh_vld)
  );

  subbr_lanes #(.DW(DW), .ALSB(ALSB)) u_lanes (
    .src(ln_src), .wdata(ln_wdata), .lane(ln_lane), .size(ln_size),
    .ext(ln_ext), .mrg(ln_mrg)
  );
endmodule

// File: rtl/subbr_chk.sv
module subbr_chk #(
  parameter int            AW      = 8,
  parameter logic [AW-1:0] BS_OFF  = AW'(8'h04),
  parameter logic [AW-1:0] BC_OFF  = AW'(8'h06),
  parameter logic [AW-1:0] TM_OFF  = AW'(8'h0C),
  parameter logic [AW-1:0] CMD_OFF = AW'(8'h0E)
) (
  input logic          clk,
  input logic          rst,
  input logic          host_req,
  input logic          host_we,
  input logic [1:0]    host_size,
  input logic [AW-1:0] host_addr,
  input logic          host_ack,
  input logic          dn_req,
  input logic          dn_we,
  input logic [AW-1:0] dn_addr,
  input logic          dn_ack
);
  localparam logic [AW-1:0] BS_WORD  = {BS_OFF[AW-1:2], 2'b00};
  localparam logic [AW-1:0] CMD_WORD = {CMD_OFF[AW-1:2], 2'b00};

  logic half_wr;
  assign half_wr = host_req && host_we && (host_size == 2'd1);

  p_dn_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> (dn_addr[1:0] == 2'b00));

  p_mode_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (half_wr && host_addr == TM_OFF && dn_req) |-> !dn_we);

  p_blk_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (half_wr && (host_addr == BS_OFF || host_addr == BC_OFF) && dn_req) |-> !dn_we);

  p_cmd_after_flush_r6: assert property (@(posedge clk) disable iff (rst)
    (half_wr && host_addr == CMD_OFF && dn_req && dn_ack && dn_we && dn_addr == BS_WORD)
      |=> (dn_req && dn_we && dn_addr == CMD_WORD));

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  p_dn_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_we)));

  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> (!host_ack && !dn_req));
endmodule

bind subword_bridge subbr_chk #(
  .AW(AW), .BS_OFF(BS_OFF), .BC_OFF(BC_OFF), .TM_OFF(TM_OFF), .CMD_OFF(CMD_OFF)
) u_chk (
  .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
  .host_size(host_size), .host_addr(host_addr), .host_ack(host_ack),
  .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_ack(dn_ack)
);

// File: tb/tb_subword_bridge.sv
`timescale 1ns/1ps
module tb_subword_bridge;
  localparam int LAT = 1;
  localparam int NV  = 14;
  localparam int VW  = 75;
  // {we, size, addr, wdata, expected read}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 2'd2, 8'h08, 32'h0, 32'h23222120},
    {1'b0, 2'd0, 8'h09, 32'h0, 32'h00000021},
    {1'b0, 2'd0, 8'h0B, 32'h0, 32'h00000023},
    {1'b0, 2'd1, 8'h0A, 32'h0, 32'h00002322},
    {1'b0, 2'd0, 8'h10, 32'h0, 32'h00000040},
    {1'b1, 2'd0, 8'h11, 32'h000000AB, 32'h0},
    {1'b0, 2'd2, 8'h10, 32'h0, 32'h4342AB40},
    {1'b1, 2'd1, 8'h12, 32'h0000BEEF, 32'h0},
    {1'b0, 2'd2, 8'h10, 32'h0, 32'hBEEFAB40},
    {1'b1, 2'd2, 8'h14, 32'hCAFEF00D, 32'h0},
    {1'b0, 2'd1, 8'h16, 32'h0, 32'h0000CAFE},
    {1'b0, 2'd0, 8'h17, 32'h0, 32'h000000CA},
    {1'b1, 2'd1, 8'h0A, 32'h00005A5A, 32'h0},
    {1'b0, 2'd2, 8'h08, 32'h0, 32'h5A5A2120}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [1:0]  host_size = 2'd0;
  logic [7:0]  host_addr = 8'h0;
  logic [31:0] host_wdata = 32'h0;
  logic host_ack;
  logic [31:0] host_rdata;
  logic dn_req, dn_we;
  logic [7:0]  dn_addr;
  logic [31:0] dn_wdata;
  logic dn_ack = 1'b0;
  logic [31:0] dn_rdata = 32'h0;

  logic [31:0] mem [64];
  logic [7:0]  wlog_a [64];
  logic [31:0] wlog_d [64];
  int wcnt = 0, rcnt = 0, lc = 0;
  int nchk = 0, nfail = 0, cyc = 0;

  always #5 clk = ~clk;

  subword_bridge dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_size(host_size), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata)
  );

  // register-file model: acks after LAT idle cycles
  always @(negedge clk) begin
    if (rst) begin
      dn_ack <= 1'b0;
      lc     <= 0;
    end else if (dn_ack) begin
      dn_ack <= 1'b0;
    end else if (dn_req) begin
      if (lc == LAT) begin
        lc     <= 0;
        dn_ack <= 1'b1;
        if (dn_we) begin
          mem[dn_addr[7:2]] <= dn_wdata;
          wlog_a[wcnt[5:0]] <= dn_addr;
          wlog_d[wcnt[5:0]] <= dn_wdata;
          wcnt <= wcnt + 1;
        end else begin
          dn_rdata <= mem[dn_addr[7:2]];
          rcnt <= rcnt + 1;
        end
      end else begin
        lc <= lc + 1;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nchk++;
      nfail++;
      $display("FAIL R10: watchdog expired actual %0d expected <150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_size = sz; host_addr = a; host_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_ack && lat < 200);
    if (!host_ack) begin
      nchk++;
      nfail++;
      $display("FAIL R10: no ack actual 0 expected 1");
    end
    rd = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 ack low in reset", {31'h0, host_ack}, 32'h0);
    chk("R11 dn_req low in reset", {31'h0, dn_req}, 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    int lat, w0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h03020100 + i * 32'h10101010;
    do_reset();

    // table walk
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][74], VEC[i][73:72], VEC[i][71:64], VEC[i][63:32], rd, lat);
      if (!VEC[i][74]) chk($sformatf("R2/R3/R9 vector %0d", i), rd, VEC[i][31:0]);
    end

    // latency of a plain word read
    access(1'b0, 2'd2, 8'h00, 32'h0, rd, lat);
    chk("R10 word read data", rd, 32'h03020100);
    chk("R10 word read latency", lat, 3);

    // RMW on a non-shadowed word, unaligned host address
    w0 = wcnt;
    access(1'b1, 2'd0, 8'h22, 32'h77, rd, lat);
    chk("R3 one write per rmw", wcnt - w0, 1);
    chk("R1 aligned address", {24'h0, wlog_a[w0[5:0]]}, 32'h20);
    chk("R3 merged word", wlog_d[w0[5:0]], 32'h83778180);

    // block size into shadow
    w0 = wcnt;
    access(1'b1, 2'd1, 8'h04, 32'h0200, rd, lat);
    chk("R5 no write for block size", wcnt - w0, 0);
    access(1'b0, 2'd1, 8'h04, 32'h0, rd, lat);
    chk("R8 block size from shadow", rd, 32'h0200);
    chk("R10 shadow read latency", lat, 1);
    access(1'b0, 2'd1, 8'h06, 32'h0, rd, lat);
    chk("R8 block count from shadow", rd, 32'h1312);

    // block count merges into valid shadow, not the register
    mem[1] = 32'hDEADDEAD;
    access(1'b1, 2'd1, 8'h06, 32'h0008, rd, lat);
    access(1'b0, 2'd1, 8'h04, 32'h0, rd, lat);
    chk("R5 size kept in shadow", rd, 32'h0200);
    access(1'b0, 2'd1, 8'h06, 32'h0, rd, lat);
    chk("R5 count in shadow", rd, 32'h0008);
    access(1'b0, 2'd2, 8'h04, 32'h0, rd, lat);
    chk("R9 word read bypasses shadow", rd, 32'hDEADDEAD);

    // transfer mode into shadow
    w0 = wcnt;
    access(1'b1, 2'd1, 8'h0C, 32'h0011, rd, lat);
    chk("R4 no write for transfer mode", wcnt - w0, 0);
    access(1'b0, 2'd1, 8'h0C, 32'h0, rd, lat);
    chk("R8 transfer mode from shadow", rd, 32'h0011);

    // command commits block then command
    w0 = wcnt;
    access(1'b1, 2'd1, 8'h0E, 32'h1234, rd, lat);
    chk("R6 two writes", wcnt - w0, 2);
    chk("R6 first write address", {24'h0, wlog_a[w0[5:0]]}, 32'h04);
    chk("R6 first write data", wlog_d[w0[5:0]], 32'h00080200);
    chk("R6 second write address", {24'h0, wlog_a[(w0 + 1) & 63]}, 32'h0C);
    chk("R6 second write data", wlog_d[(w0 + 1) & 63], 32'h12340011);

    // shadows no longer valid
    mem[3] = 32'h55556666;
    mem[1] = 32'h77778888;
    access(1'b0, 2'd1, 8'h0C, 32'h0, rd, lat);
    chk("R8 mode from register after commit", rd, 32'h6666);
    access(1'b0, 2'd1, 8'h04, 32'h0, rd, lat);
    chk("R8 size from register after commit", rd, 32'h8888);

    // command alone uses retained shadow contents
    w0 = wcnt;
    access(1'b1, 2'd1, 8'h0E, 32'h0042, rd, lat);
    chk("R6 single write", wcnt - w0, 1);
    chk("R7 command word from shadow", wlog_d[w0[5:0]], 32'h00420011);

    // reset drops pending shadow
    access(1'b1, 2'd1, 8'h0C, 32'h00AA, rd, lat);
    do_reset();
    access(1'b0, 2'd1, 8'h0C, 32'h0, rd, lat);
    chk("R11 shadow cleared by reset", rd, 32'h0011);

    finish_run();
  end
endmodule